// File: doc/BRIEF.md
# Timer-Synchronized Byte GPIO Port

An eight-pin general-purpose I/O port sitting behind a small register bus. Each pin carries its own direction bit and its own drive-mode bit, which selects push-pull or open-drain. Software writes output data into a holding register. That data moves to the pins only when an update strobe fires. Each half of the byte chooses its strobe independently: either every system clock, or one of three timer pulses that arrive as plain inputs. This lets a whole nibble change on an exact timer tick rather than at the moment of the bus write.

Six of the pins can be handed over, bit by bit, to serial-port transmit data and clock signals through an alternate-function register. The pin levels pass through a two-flop synchronizer. The synchronized value feeds both the data-register read path and an output bus toward the serial receivers, so an input pin can carry received data or a received clock. Pads are modelled as an output-enable / output-value pair per pin together with a pin-level input.

Top module: `gpio_byte_port`

## Requirements
- R1: After reset every direction bit, drive bit, function bit and both update selects are 0, so `pin_oe_o` is 0x00. The synchronizer also clears, so a read of the data address 0x48 returns 0x00 until pin levels propagate.
- R2: With direction bit i = 1 and drive bit i = 0, `pin_oe_o[i]` is 1 and `pin_do_o[i]` follows the pin's output value. With direction bit i = 0, `pin_oe_o[i]` is 0. `pin_do_o[i]` is 0 whenever `pin_oe_o[i]` is 0.
- R3: With drive bit i = 1 (address 0x4E) and direction bit i = 1 (address 0x4F), a pin output value of 0 gives `pin_oe_o[i]`=1 with `pin_do_o[i]`=0. An output value of 1 releases the pin, giving `pin_oe_o[i]`=0.
- R4: A write to 0x48 loads the holding register on the write edge. A nibble whose select is 00 copies the holding register into its output register on the following clock edge.
- R5: The lower-nibble select occupies control bits [1:0] and the upper-nibble select occupies bits [5:4], both at address 0x4C. The codes are 01 = timer A1, 10 = timer B1, 11 = timer B2. A nibble with a nonzero select keeps its output register until its chosen strobe is high on a clock edge, and strobes of the other timers leave it unchanged.
- R6: The two nibbles update independently. A strobe that updates one nibble leaves the other nibble's pins unchanged.
- R7: With function bit i set (address 0x4D), the pin's output value comes from the alternate signal: bit 6 = E transmit data, bit 5 = E receive clock, bit 4 = E transmit clock, bit 2 = F transmit data, bit 1 = F receive clock, bit 0 = F transmit clock. Function bits 7 and 3 have no effect.
- R8: A read of 0x48 returns the pin levels as they stood two clock edges earlier, regardless of direction.
- R9: Reads of 0x4C, 0x4D, 0x4E, 0x4F and any other non-data address return 0x00. Writes to unmapped addresses change no register.
- R10: `ser_rx_o` always equals the synchronized pin levels, the same value a data read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | One-cycle write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tmr_a1_i | input | 1 | Timer A1 update pulse |
| tmr_b1_i | input | 1 | Timer B1 update pulse |
| tmr_b2_i | input | 1 | Timer B2 update pulse |
| ser_e_txd_i | input | 1 | Serial E transmit data |
| ser_e_rclk_i | input | 1 | Serial E receive clock out |
| ser_e_tclk_i | input | 1 | Serial E transmit clock out |
| ser_f_txd_i | input | 1 | Serial F transmit data |
| ser_f_rclk_i | input | 1 | Serial F receive clock out |
| ser_f_tclk_i | input | 1 | Serial F transmit clock out |
| pin_i | input | 8 | Pad levels |
| pin_oe_o | output | 8 | Pad output enables |
| pin_do_o | output | 8 | Pad output values |
| ser_rx_o | output | 8 | Synchronized pin levels to serial receivers |

## Verification
The bench builds the port with its default parameters: an eight-bit byte split into two four-bit nibbles and a two-stage synchronizer. These defaults put both nibble selects, all three timer strobes and all six alternate-function bits within reach, along with the two unmapped function bits. With the two-stage depth, the read-back latency is an exact two cycles, which the per-cycle reference model tracks. Open-drain release and the independence of the nibbles are exercised with mixed patterns, so a wrong nibble boundary or a swapped strobe code shows up on the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int N_NIB  = BYTE_W / NIB_W;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_DATA = 8'h48;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h4C;
  localparam logic [ADDR_W-1:0] ADR_FUNC = 8'h4D;
  localparam logic [ADDR_W-1:0] ADR_DRV  = 8'h4E;
  localparam logic [ADDR_W-1:0] ADR_DIR  = 8'h4F;

  // pins that own an alternate serial signal
  localparam logic [BYTE_W-1:0] ALT_MASK = 8'h77;

  typedef enum logic [1:0] {
    UPD_NOW = 2'b00,
    UPD_TA1 = 2'b01,
    UPD_TB1 = 2'b10,
    UPD_TB2 = 2'b11
  } upd_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] hold_o,
  output upd_sel_e          sel_o [N_NIB],
  output logic [BYTE_W-1:0] func_o,
  output logic [BYTE_W-1:0] drv_o,
  output logic [BYTE_W-1:0] dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      func_o <= '0;
      drv_o  <= '0;
      dir_o  <= '0;
      for (int n = 0; n < N_NIB; n++) sel_o[n] <= UPD_NOW;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADR_DATA: hold_o <= wdata_i;
        ADR_CTRL: for (int n = 0; n < N_NIB; n++)
                    sel_o[n] <= upd_sel_e'(wdata_i[n*NIB_W +: 2]);
        ADR_FUNC: func_o <= wdata_i;
        ADR_DRV:  drv_o  <= wdata_i;
        ADR_DIR:  dir_o  <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_nib_upd.sv
module gpio_nib_upd
  import gpio_port_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  upd_sel_e     sel_i,
  input  logic         tmr_a1_i,
  input  logic         tmr_b1_i,
  input  logic         tmr_b2_i,
  input  logic [W-1:0] hold_i,
  output logic [W-1:0] out_o
);
  logic fire;

  always_comb begin
    unique case (sel_i)
      UPD_NOW: fire = 1'b1;
      UPD_TA1: fire = tmr_a1_i;
      UPD_TB1: fire = tmr_b1_i;
      UPD_TB2: fire = tmr_b2_i;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_o <= '0;
    else if (fire) out_o <= hold_i;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_byte_port.sv
module gpio_byte_port
  import gpio_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              tmr_a1_i,
  input  logic              tmr_b1_i,
  input  logic              tmr_b2_i,
  input  logic              ser_e_txd_i,
  input  logic              ser_e_rclk_i,
  input  logic              ser_e_tclk_i,
  input  logic              ser_f_txd_i,
  input  logic              ser_f_rclk_i,
  input  logic              ser_f_tclk_i,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_oe_o,
  output logic [BYTE_W-1:0] pin_do_o,
  output logic [BYTE_W-1:0] ser_rx_o
);
  logic [BYTE_W-1:0] hold_q, func_q, drv_q, dir_q, out_q, sync_q;
  logic [BYTE_W-1:0] alt_v, val_v;
  upd_sel_e          sel_q [N_NIB];

  gpio_port_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .hold_o(hold_q), .sel_o(sel_q), .func_o(func_q),
    .drv_o(drv_q), .dir_o(dir_q)
  );

  for (genvar n = 0; n < N_NIB; n++) begin : g_nib
    gpio_nib_upd #(.W(NIB_W)) u_nib (
      .clk_i, .rst_ni,
      .sel_i   (sel_q[n]),
      .tmr_a1_i, .tmr_b1_i, .tmr_b2_i,
      .hold_i  (hold_q[n*NIB_W +: NIB_W]),
      .out_o   (out_q[n*NIB_W +: NIB_W])
    );
  end

  gpio_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_q)
  );

  assign alt_v = {1'b0, ser_e_txd_i, ser_e_rclk_i, ser_e_tclk_i,
                  1'b0, ser_f_txd_i, ser_f_rclk_i, ser_f_tclk_i};

  for (genvar i = 0; i < BYTE_W; i++) begin : g_pin
    assign val_v[i] = (ALT_MASK[i] && func_q[i]) ? alt_v[i] : out_q[i];
    // open-drain: drive only the low level
    assign pin_oe_o[i] = dir_q[i] & (drv_q[i] ? ~val_v[i] : 1'b1);
    assign pin_do_o[i] = pin_oe_o[i] & val_v[i];
  end

  assign rdata_o  = (addr_i == ADR_DATA) ? sync_q : '0;
  assign ser_rx_o = sync_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              tmr_a1_i,
  input logic              tmr_b2_i,
  input logic [BYTE_W-1:0] pin_i,
  input logic [BYTE_W-1:0] pin_oe_o,
  input logic [BYTE_W-1:0] pin_do_o,
  input logic [BYTE_W-1:0] ser_rx_o,
  input logic [BYTE_W-1:0] hold_q,
  input logic [BYTE_W-1:0] out_q,
  input logic [BYTE_W-1:0] drv_q,
  input logic [BYTE_W-1:0] dir_q,
  input upd_sel_e          sel_lo,
  input upd_sel_e          sel_hi
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_inputs_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == '0) |-> (pin_oe_o == '0));

  assert_no_drive_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_do_o & ~pin_oe_o) == '0);

  assert_od_never_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pin_do_o & drv_q) == '0);

  assert_now_follows_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_lo == UPD_NOW) |=> (out_q[3:0] == $past(hold_q[3:0])));

  assert_lo_waits_a1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_lo == UPD_TA1 && !tmr_a1_i) |=> $stable(out_q[3:0]));

  assert_hi_waits_b2_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_hi == UPD_TB2 && !tmr_b2_i) |=> $stable(out_q[7:4]));

  assert_sync_depth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (ser_rx_o == $past(pin_i, 2)));

  assert_wo_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADR_DATA) |-> (rdata_o == '0));

  assert_rx_matches_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_DATA) |-> (rdata_o == ser_rx_o));
endmodule

bind gpio_byte_port gpio_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o),
  .tmr_a1_i(tmr_a1_i), .tmr_b2_i(tmr_b2_i), .pin_i(pin_i),
  .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o), .ser_rx_o(ser_rx_o),
  .hold_q(hold_q), .out_q(out_q), .drv_q(drv_q), .dir_q(dir_q),
  .sel_lo(sel_q[0]), .sel_hi(sel_q[1])
);

// File: tb/sim_gpio_byte_port.sv
`timescale 1ns/1ps
module sim_gpio_byte_port;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [7:0] addr = 8'h48, wdata = 0, rdata;
  logic ta1 = 0, tb1 = 0, tb2 = 0;
  logic e_txd = 0, e_rclk = 0, e_tclk = 0, f_txd = 0, f_rclk = 0, f_tclk = 0;
  logic [7:0] pins = 0, oe, dout, srx;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  gpio_byte_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .tmr_a1_i(ta1), .tmr_b1_i(tb1), .tmr_b2_i(tb2),
    .ser_e_txd_i(e_txd), .ser_e_rclk_i(e_rclk), .ser_e_tclk_i(e_tclk),
    .ser_f_txd_i(f_txd), .ser_f_rclk_i(f_rclk), .ser_f_tclk_i(f_tclk),
    .pin_i(pins), .pin_oe_o(oe), .pin_do_o(dout), .ser_rx_o(srx)
  );

  // reference model state
  logic [7:0] m_hold, m_func, m_drv, m_dir, m_out, m_s1, m_s2;
  logic [1:0] m_sel [2];

  function automatic bit m_fire(input logic [1:0] s);
    case (s)
      2'd0: return 1'b1;
      2'd1: return ta1;
      2'd2: return tb1;
      default: return tb2;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_func = 0; m_drv = 0; m_dir = 0; m_out = 0;
      m_s1 = 0; m_s2 = 0; m_sel[0] = 0; m_sel[1] = 0;
    end else begin
      logic [7:0] nout;
      nout = m_out;
      if (m_fire(m_sel[0])) nout[3:0] = m_hold[3:0];
      if (m_fire(m_sel[1])) nout[7:4] = m_hold[7:4];
      m_s2 = m_s1; m_s1 = pins; m_out = nout;
      if (wr_en) begin
        case (addr)
          8'h48: m_hold = wdata;
          8'h4C: begin m_sel[0] = wdata[1:0]; m_sel[1] = wdata[5:4]; end
          8'h4D: m_func = wdata;
          8'h4E: m_drv = wdata;
          8'h4F: m_dir = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic void exp_pins(output logic [7:0] eoe, output logic [7:0] edo);
    logic [7:0] alt;
    alt = {1'b0, e_txd, e_rclk, e_tclk, 1'b0, f_txd, f_rclk, f_tclk};
    for (int i = 0; i < 8; i++) begin
      logic v;
      v = (m_func[i] && i != 7 && i != 3) ? alt[i] : m_out[i];
      if (!m_dir[i])    begin eoe[i] = 0;  edo[i] = 0; end
      else if (m_drv[i]) begin eoe[i] = !v; edo[i] = 0; end
      else              begin eoe[i] = 1;  edo[i] = v; end
    end
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [7:0] eoe, edo;
      exp_pins(eoe, edo);
      chk(cur_req, "model oe", oe, eoe);
      chk(cur_req, "model do", dout, edo);
      chk(cur_req, "model rdata", rdata, (addr == 8'h48) ? m_s2 : 8'h00);
      chk("R10", "model ser_rx", srx, m_s2);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 8'h48;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: ta1 = 1; 1: tb1 = 1; default: tb2 = 1; endcase
    @(negedge clk); ta1 = 0; tb1 = 0; tb2 = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(3);
    cur_req = "R1";
    chk("R1", "oe after reset", oe, 8'h00);
    chk("R1", "read after reset", rdata, 8'h00);

    cur_req = "R2";
    wr(8'h4F, 8'hFF); wr(8'h48, 8'hA5); idle(2);
    chk("R2", "push-pull do", dout, 8'hA5);
    chk("R2", "push-pull oe", oe, 8'hFF);
    wr(8'h4F, 8'h0F); idle(1);
    chk("R2", "partial oe", oe, 8'h0F);
    chk("R2", "partial do", dout, 8'h05);

    cur_req = "R4";
    wr(8'h4F, 8'hFF); wr(8'h48, 8'h5A);
    chk("R4", "pins before copy", dout, 8'hA5);
    idle(1);
    chk("R4", "pins after copy", dout, 8'h5A);

    cur_req = "R3";
    wr(8'h4E, 8'hF0); idle(1);
    chk("R3", "od oe", oe, 8'hAF);
    chk("R3", "od do", dout, 8'h0A);
    wr(8'h4E, 8'h00);

    cur_req = "R5";
    wr(8'h4C, 8'h31); wr(8'h48, 8'h3C); idle(4);
    chk("R5", "held without strobe", dout, 8'h5A);
    pulse(1); idle(1);
    chk("R5", "B1 ignored", dout, 8'h5A);
    cur_req = "R6";
    pulse(0); idle(1);
    chk("R6", "A1 updates lower only", dout, 8'h5C);
    pulse(2); idle(1);
    chk("R5", "B2 updates upper", dout, 8'h3C);
    wr(8'h4C, 8'h20); wr(8'h48, 8'hC3); idle(2);
    chk("R6", "lower immediate, upper waits B1", dout, 8'h33);
    pulse(1); idle(1);
    chk("R5", "B1 updates upper", dout, 8'hC3);
    wr(8'h4C, 8'h00);

    cur_req = "R7";
    wr(8'h48, 8'h00); idle(2);
    @(negedge clk); e_txd = 1; e_tclk = 1; f_rclk = 1;
    wr(8'h4D, 8'hFF); idle(1);
    chk("R7", "alt map", dout, 8'h52);
    wr(8'h48, 8'h88); idle(2);
    chk("R7", "bits 7,3 stay gpio", dout, 8'hDA);
    @(negedge clk); e_txd = 0; e_rclk = 1; e_tclk = 0; f_txd = 1; f_rclk = 0; f_tclk = 1;
    idle(1);
    chk("R7", "alt map 2", dout, 8'hAD);
    wr(8'h4D, 8'h00); wr(8'h48, 8'h00);

    cur_req = "R8";
    wr(8'h4F, 8'h00);
    @(negedge clk); pins = 8'h96;
    idle(1);
    chk("R8", "one edge not yet", rdata, 8'h00);
    idle(1);
    chk("R8", "read pins", rdata, 8'h96);
    chk("R10", "ser_rx pins", srx, 8'h96);
    wr(8'h4F, 8'hFF); @(negedge clk); pins = 8'h3B; idle(2);
    chk("R8", "read while output", rdata, 8'h3B);

    cur_req = "R9";
    for (int a = 8'h4C; a <= 8'h4F; a++) begin
      @(negedge clk); addr = a[7:0]; #1;
      chk("R9", "write-only reads 0", rdata, 8'h00);
    end
    @(negedge clk); addr = 8'h48;
    wr(8'h48, 8'h71); idle(2);
    wr(8'h50, 8'h00); wr(8'h4B, 8'h00); idle(2);
    chk("R9", "unmapped write ignored do", dout, 8'h71);
    chk("R9", "unmapped write ignored oe", oe, 8'hFF);

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule